// File: doc/BRIEF.md
# Bus-Master IDE DMA Engine

This block is the device-side bus-master DMA controller for a single IDE channel. Software programs it through an eight-port I/O window: a command byte that starts or stops the engine and selects the transfer direction, a status byte with an active flag and two sticky flags that are cleared by writing 1, and a four-byte pointer to a table of physical region descriptors in memory.

When started, the engine reads descriptors one at a time over a request/response memory port. Each descriptor gives a region address, a byte count and an end-of-table flag. The engine passes the region to an external data mover with a one-cycle start pulse and waits for the mover to report completion. It then either fetches the next descriptor or, after the end-of-table entry, completes the transfer. On completion it clears the active flag, clears the error flag, sets the interrupt flag, reports an idle drive status and raises its interrupt line.

Top module: `ide_bm_dma`

## Requirements
- R1: The register window is the eight I/O ports starting at parameter WIN_BASE (default 0xC000; the second channel's window would start at 0xC008). Writes outside the window change nothing, and reads outside it return 0.
- R2: A command write (offset 0) stores the written byte ANDed with 0x09, so only bit 0 (start) and bit 3 (direction, 1 = device to memory) are kept. The stored value reads back at offset 0.
- R3: A command write that sets bit 0 while the stored bit 0 is 0 starts a walk. The table index is reset to 0, status bit 0 (active) reads 1, the drive status output becomes 0x80 (busy), and in the next cycle a fetch is requested at the table base.
- R4: Each descriptor fetch uses address = table base + 8 × table index, where the base is stored little-endian at offsets 4 to 7. mem_req and mem_addr are held until mem_rvalid is seen.
- R5: A descriptor is 64 bits: bits 31:0 are the region address, bits 47:32 are the byte count (0 means 65536), and bit 63 is the end-of-table flag. In the cycle after the response, mv_start is high for exactly one cycle with mv_addr, mv_len (17 bits) and mv_dir equal to command bit 3.
- R6: When mv_done ends a descriptor without the end flag, the index advances by one and the next fetch is requested in the following cycle. No interrupt is raised.
- R7: When mv_done ends the end-of-table descriptor, the status byte reads 0x04 (active 0, error 0, interrupt 1), the drive status becomes 0x50 (ready and seek-complete), irq goes high and no further fetch is requested.
- R8: Status bit 1 (error) and bit 2 (interrupt) clear when 1 is written to them. Writing 0 leaves them unchanged, and writes do not affect bit 0 (active). irq follows status bit 2.
- R9: A command write with bit 0 clear during a walk aborts it: active reads 0, no interrupt is raised, no further fetch is requested and later mv_done pulses are ignored.
- R10: A descriptor response with mem_rerr set stops the walk: status reads 0x06 (error and interrupt set, active 0), irq goes high and no mover start is issued.
- R11: After synchronous reset, command, status and table base read 0, irq and mem_req are 0, and drive status is 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address for reads and writes |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Combinational read data for io_addr |
| mem_req | output | 1 | Descriptor fetch request |
| mem_addr | output | 32 | Descriptor fetch address |
| mem_rvalid | input | 1 | Descriptor response valid |
| mem_rdata | input | 64 | Descriptor response data |
| mem_rerr | input | 1 | Descriptor response error |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_addr | output | 32 | Region address for the mover |
| mv_len | output | 17 | Region length in bytes |
| mv_dir | output | 1 | Transfer direction (1 = device to memory) |
| mv_done | input | 1 | Mover finished the current region |
| drv_status | output | 8 | Drive status byte reported to the channel |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench walks a four-entry chain that includes a zero byte count, so an engine that passed 0 as a length instead of 65536 shows a wrong mv_len. A wrong fetch stride or a lost index increment shows up as a wrong mem_addr. A design that raised the interrupt on every descriptor, or left the error flag set at the end, fails the per-descriptor irq check and the final status read of 0x04. An abort in the middle of a walk, an errored fetch, restart behaviour, command masking, clear-by-writing-1 semantics and writes to the neighbouring channel's window are each checked on their own. A design that kept unmasked command bits, cleared flags on a write of 0, let a stopped walk keep fetching, or decoded the wrong window would show different read-back values.

// File: rtl/ide_bm_dma_pkg.sv
package ide_bm_dma_pkg;

    // Register offsets inside the eight-port window
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_BASE = 3'd4;

    localparam logic [7:0] CMD_KEEP  = 8'h09;  // start (bit 0), direction (bit 3)
    localparam logic [7:0] DRV_BUSY  = 8'h80;
    localparam logic [7:0] DRV_READY = 8'h50;  // ready + seek complete

    localparam int PRD_SHIFT = 3;              // descriptor is 8 bytes

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_ISSUE,
        W_WAIT
    } walk_state_t;

    typedef struct packed {
        logic        last;
        logic [14:0] resv;
        logic [15:0] count;
        logic [31:0] addr;
    } prd_t;

    function automatic logic [16:0] prd_len(input logic [15:0] count);
        return (count == 16'd0) ? 17'h10000 : {1'b0, count};
    endfunction

endpackage

// File: rtl/ide_bm_dma_regs.sv
module ide_bm_dma_regs
    import ide_bm_dma_pkg::*;
#(
    parameter int          IO_W     = 16,
    parameter logic [15:0] WIN_BASE = 16'hC000,
    parameter int          ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              active,
    input  logic              done_evt,
    input  logic              err_evt,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              dir,
    output logic [ADDR_W-1:0] tbl_base,
    output logic              int_flag
);
    localparam int NB = ADDR_W / 8;

    logic       hit;
    logic [2:0] off;
    logic       wr_cmd, wr_stat;
    logic [7:0] cmd_q;
    logic       err_q, int_q;
    logic [7:0] base_b [NB];

    assign hit     = (io_addr[IO_W-1:3] == WIN_BASE[IO_W-1:3]);
    assign off     = io_addr[2:0];
    assign wr_cmd  = io_wr && hit && (off == OFF_CMD);
    assign wr_stat = io_wr && hit && (off == OFF_STAT);

    assign start_pulse = wr_cmd && io_wdata[0] && !cmd_q[0];
    assign stop_pulse  = wr_cmd && !io_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= 8'h00;
        end else if (wr_cmd) begin
            cmd_q <= io_wdata & CMD_KEEP;
        end
    end

    // Sticky flags: events set, writing 1 clears, set wins
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            int_q <= 1'b0;
        end else if (err_evt) begin
            err_q <= 1'b1;
            int_q <= 1'b1;
        end else if (done_evt) begin
            err_q <= 1'b0;
            int_q <= 1'b1;
        end else if (wr_stat) begin
            if (io_wdata[1]) err_q <= 1'b0;
            if (io_wdata[2]) int_q <= 1'b0;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst) begin
                base_b[b] <= 8'h00;
            end else if (io_wr && hit && (off == 3'(OFF_BASE + b))) begin
                base_b[b] <= io_wdata;
            end
        end
        assign tbl_base[8*b +: 8] = base_b[b];
    end

    always_comb begin
        io_rdata = 8'h00;
        if (hit) begin
            if (off == OFF_CMD) begin
                io_rdata = cmd_q;
            end else if (off == OFF_STAT) begin
                io_rdata = {5'b0, int_q, err_q, active};
            end else if (off[2]) begin
                io_rdata = base_b[off[1:0]];
            end
        end
    end

    assign dir      = cmd_q[3];
    assign int_flag = int_q;

    assert_err_flags_R10: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> (err_q && int_q));

    assert_end_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (done_evt && !err_evt) |=> (int_q && !err_q));

endmodule

// File: rtl/ide_bm_dma_walker.sv
module ide_bm_dma_walker
    import ide_bm_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [16:0]       mv_len,
    input  logic              mv_done,
    output logic              active,
    output logic              done_evt,
    output logic              err_evt,
    output logic [7:0]        drv_status
);
    walk_state_t      state;
    logic [IDX_W-1:0] idx;
    prd_t             rsp;
    logic             last_q;
    logic [15:0]      count_q;
    logic [31:0]      addr_q;
    logic [7:0]       drv_q;
    logic [14:0]      resv_unused;

    assign rsp         = prd_t'(mem_rdata);
    assign resv_unused = rsp.resv;

    assign mem_req  = (state == W_FETCH);
    assign mem_addr = tbl_base + ADDR_W'({idx, {PRD_SHIFT{1'b0}}});
    assign mv_start = (state == W_ISSUE);
    assign mv_addr  = ADDR_W'(addr_q);
    assign mv_len   = prd_len(count_q);
    assign active   = (state != W_IDLE);

    assign done_evt = !stop && (state == W_WAIT) && mv_done && last_q;
    assign err_evt  = !stop && (state == W_FETCH) && mem_rvalid && mem_rerr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            idx     <= '0;
            last_q  <= 1'b0;
            count_q <= '0;
            addr_q  <= '0;
            drv_q   <= DRV_READY;
        end else if (stop) begin
            state <= W_IDLE;
        end else begin
            unique case (state)
                W_IDLE: if (start) begin
                    state <= W_FETCH;
                    idx   <= '0;
                    drv_q <= DRV_BUSY;
                end
                W_FETCH: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        state <= W_IDLE;
                    end else begin
                        last_q  <= rsp.last;
                        count_q <= rsp.count;
                        addr_q  <= rsp.addr;
                        state   <= W_ISSUE;
                    end
                end
                W_ISSUE: state <= W_WAIT;
                W_WAIT: if (mv_done) begin
                    if (last_q) begin
                        state <= W_IDLE;
                        drv_q <= DRV_READY;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= W_FETCH;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign drv_status = drv_q;

    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid && !stop) |=> (mem_req && $stable(mem_addr)));

    assert_issue_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    assert_start_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !active) |=> (mem_req && mem_addr == $past(tbl_base)));

    assert_req_active_R9: assert property (@(posedge clk) disable iff (rst)
        stop |=> !mem_req);

    assert_end_status_R7: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> (drv_status == DRV_READY && !active));

endmodule

// File: rtl/ide_bm_dma.sv
module ide_bm_dma
    import ide_bm_dma_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          IO_W     = 16,
    parameter logic [15:0] WIN_BASE = 16'hC000,
    parameter int          IDX_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [16:0]       mv_len,
    output logic              mv_dir,
    input  logic              mv_done,
    output logic [7:0]        drv_status,
    output logic              irq
);
    logic              active, done_evt, err_evt;
    logic              start_pulse, stop_pulse;
    logic [ADDR_W-1:0] tbl_base;

    ide_bm_dma_regs #(
        .IO_W(IO_W), .WIN_BASE(WIN_BASE), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst(rst),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .active(active), .done_evt(done_evt), .err_evt(err_evt),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .dir(mv_dir), .tbl_base(tbl_base), .int_flag(irq)
    );

    ide_bm_dma_walker #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) i_walker (
        .clk(clk), .rst(rst),
        .start(start_pulse), .stop(stop_pulse), .tbl_base(tbl_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
        .active(active), .done_evt(done_evt), .err_evt(err_evt),
        .drv_status(drv_status)
    );

    assert_irq_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !active);

endmodule

// File: tb/test_ide_bm_dma.sv
module test_ide_bm_dma;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        mem_rerr;
    logic        mv_start;
    logic [31:0] mv_addr;
    logic [16:0] mv_len;
    logic        mv_dir;
    logic        mv_done;
    logic [7:0]  drv_status;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam int NV = 4;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0008_0000, 32'h0010_0200, 32'h0000_0010, 32'h7FFF_FFFE};
    localparam logic [15:0] V_CNT  [NV] = '{16'h0200, 16'h0000, 16'h0001, 16'hFFFE};
    localparam logic [16:0] V_LEN  [NV] = '{17'h00200, 17'h10000, 17'h00001, 17'h0FFFE};
    localparam logic [31:0] TBL = 32'h0000_1000;

    always #5 clk = ~clk;

    ide_bm_dma i_ide_bm_dma (
        .clk(clk), .rst(rst),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_len(mv_len), .mv_dir(mv_dir),
        .mv_done(mv_done), .drv_status(drv_status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic resp(input logic [63:0] d, input logic e);
        mem_rdata = d; mem_rvalid = 1'b1; mem_rerr = e;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rerr = 1'b0;
    endtask

    task automatic done_pulse();
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
    endtask

    task automatic wait_req(input string tag);
        for (int k = 0; k < 20 && !mem_req; k++) @(negedge clk);
        chk(tag, mem_req, 1'b1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; io_wr = 1'b0; io_addr = 16'h0; io_wdata = 8'h0;
        mem_rvalid = 1'b0; mem_rdata = '0; mem_rerr = 1'b0; mv_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        rd(16'hC000, r); chk("R11 cmd", r, 8'h00);
        rd(16'hC002, r); chk("R11 status", r, 8'h00);
        for (int b = 0; b < 4; b++) begin
            rd(16'hC004 + 16'(b), r); chk("R11 base", r, 8'h00);
        end
        chk("R11 irq", irq, 1'b0);
        chk("R11 mem_req", mem_req, 1'b0);
        chk("R11 drv_status", drv_status, 8'h50);

        // R2: command masking
        wr(16'hC000, 8'hFE);
        rd(16'hC000, r); chk("R2 mask 0xFE", r, 8'h08);
        wr(16'hC000, 8'h00);

        // R1/R4: base write and window decode
        for (int b = 0; b < 4; b++) wr(16'hC004 + 16'(b), TBL[8*b +: 8]);
        rd(16'hC005, r); chk("R4 base byte1", r, 8'h10);
        wr(16'hC00C, 8'hAA);
        rd(16'hC004, r); chk("R1 out-of-window base", r, 8'h00);
        wr(16'hC008, 8'h01);
        chk("R1 out-of-window start", mem_req, 1'b0);
        rd(16'hC008, r); chk("R1 read outside", r, 8'h00);
        rd(16'hC000, r); chk("R1 cmd unchanged", r, 8'h00);

        // R3..R7: walk a descriptor chain from the vector table
        wr(16'hC000, 8'h09);
        rd(16'hC002, r); chk("R3 active", r, 8'h01);
        chk("R3 drv busy", drv_status, 8'h80);
        chk("R3 fetch requested", mem_req, 1'b1);
        for (int i = 0; i < NV; i++) begin
            wait_req("R6 next fetch");
            chk("R4 fetch addr", mem_addr, TBL + 32'(8 * i));
            @(negedge clk);
            chk("R4 request held", mem_req, 1'b1);
            resp({(i == NV - 1), 15'h0, V_CNT[i], V_ADDR[i]}, 1'b0);
            chk("R5 mv_start", mv_start, 1'b1);
            chk("R5 mv_addr", mv_addr, V_ADDR[i]);
            chk("R5 mv_len", mv_len, V_LEN[i]);
            chk("R5 mv_dir", mv_dir, 1'b1);
            @(negedge clk);
            chk("R5 single pulse", mv_start, 1'b0);
            chk("R6 no irq mid-chain", irq, 1'b0);
            done_pulse();
        end
        rd(16'hC002, r); chk("R7 status at end", r, 8'h04);
        chk("R7 drv ready", drv_status, 8'h50);
        chk("R7 irq", irq, 1'b1);
        chk("R7 no fetch", mem_req, 1'b0);

        // R8: write-1-to-clear
        wr(16'hC002, 8'h03);
        rd(16'hC002, r); chk("R8 err/active write", r, 8'h04);
        wr(16'hC002, 8'h00);
        rd(16'hC002, r); chk("R8 zero write", r, 8'h04);
        wr(16'hC002, 8'h04);
        rd(16'hC002, r); chk("R8 int cleared", r, 8'h00);
        chk("R8 irq low", irq, 1'b0);

        // R9: abort mid-walk
        wr(16'hC000, 8'h00);
        wr(16'hC000, 8'h01);
        wait_req("R9 restart fetch");
        chk("R3 index reset", mem_addr, TBL);
        resp({1'b0, 15'h0, 16'h0010, 32'h0000_4000}, 1'b0);
        chk("R5 dir 0", mv_dir, 1'b0);
        wr(16'hC000, 8'h00);
        rd(16'hC002, r); chk("R9 inactive", r, 8'h00);
        done_pulse();
        repeat (3) @(negedge clk);
        chk("R9 no fetch", mem_req, 1'b0);
        chk("R9 no irq", irq, 1'b0);

        // R10: fetch error
        wr(16'hC000, 8'h01);
        wait_req("R10 fetch");
        resp(64'h0, 1'b1);
        chk("R10 no mover start", mv_start, 1'b0);
        rd(16'hC002, r); chk("R10 status", r, 8'h06);
        chk("R10 irq", irq, 1'b1);
        chk("R10 no fetch", mem_req, 1'b0);
        wr(16'hC002, 8'h06);
        rd(16'hC002, r); chk("R8 both cleared", r, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule